// File: doc/BRIEF.md
# Chainable FIFO Slice

A 9-bit-wide first-in, first-out buffer slice that works either on its own or as one stage of a ring of identical slices. The ring shares one write strobe, one read strobe and one data input, so together the slices form a single buffer whose depth is the sum of their depths. All strobes are active low and sampled on the rising edge of the system clock. One word moves per edge while a strobe is held low.

Alone (parameter `CHAINED` = 0), the slice is a plain FIFO with empty, full and half-full flags and a rewind input. The expansion inputs are unused in this mode and should be held low. In a ring (`CHAINED` = 1), only the slice that holds the write token accepts writes, and only the slice that holds the read token returns data. When a slice writes or reads its last storage location, it raises its handoff output `xout` for that cycle. It also sets `xout_rd` to say which token is being handed over. Each slice's `xout`/`xout_rd` feed the `xin`/`xin_rd` of the next slice, and the last slice feeds the first. The slice whose `first_ld_n` is low starts out holding both tokens.

A slice drives its `dout` only in the cycle after one of its own reads, and marks that cycle with `dout_vld`. The ring's output is the OR of the data of the slices, each gated by its valid. The ring's flags are the OR of the active-low per-slice flags.

Top module: `cfifo_slice`

## Requirements
- R1: A write stores `din` when `wr_n` is low at an edge. A read, with `rd_n` low at an edge, puts the oldest stored word on `dout` and raises `dout_vld` for the following cycle. Words leave in the order they were written.
- R2: `empty_n` is low exactly when the slice stores no word. A read while empty is ignored and gives no `dout_vld`.
- R3: `full_n` is low exactly when the slice stores `DEPTH` words. A write while full is ignored and the stored words are unchanged.
- R4: With `CHAINED` = 0, `half_n` is low exactly when more than `DEPTH`/2 words are stored.
- R5: A read and a write at the same edge, with the slice neither empty nor full, both take effect. The word count does not change.
- R6: With `CHAINED` = 0, `rt_n` low at an edge moves the read position back to location 0 and sets the count to the number of locations written from location 0 (`DEPTH` if the slice is full). Reads and writes at that edge are ignored.
- R7: With `CHAINED` = 1, a slice with `first_ld_n` low holds both tokens after reset. A slice with `first_ld_n` high holds neither.
- R8: A chained slice without the write token ignores writes. A chained slice without the read token ignores reads and keeps `dout_vld` low.
- R9: `xout` is high in the cycle in which a chained slice writes or reads location `DEPTH`-1. `xout_rd` is 1 for a read handoff and 0 for a write handoff. The slice gives up that token at the edge. With `CHAINED` = 0, `xout` stays low.
- R10: `xin` high at an edge gives the receiving slice the token named by `xin_rd`. Its next strobe of that kind uses its location 0, with no idle cycle needed.
- R11: With `CHAINED` = 1, `rt_n` has no effect and `half_n` stays high.
- R12: A ring of slices keeps first-in, first-out order across slice boundaries and over repeated laps. The ORed flags show empty or full only when every slice does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data, valid when dout_vld is high |
| dout_vld | output | 1 | High in the cycle after this slice's own read |
| rt_n | input | 1 | Rewind to location 0, active low (standalone only) |
| first_ld_n | input | 1 | Low marks the slice that starts with both tokens |
| xin | input | 1 | Token handoff pulse from the previous slice |
| xin_rd | input | 1 | Kind of incoming token: 1 read, 0 write |
| xout | output | 1 | Token handoff pulse to the next slice |
| xout_rd | output | 1 | Kind of outgoing token: 1 read, 0 write |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| half_n | output | 1 | More-than-half flag, active low (standalone only) |

## Verification
A read and a write can land on the same edge. Within one slice the count must then stay the same. In a ring, one slice can hand off the write token in the same cycle that another slice serves a read. The bench provokes the first case by holding both strobes low on a partly filled standalone slice. It provokes the second by streaming twelve cycles of combined reads and writes through a ring while the write token crosses two slice boundaries. Each word is judged against a queue model, together with the flag levels and the handoff pulse seen before the edge.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
   typedef enum logic {
      TOK_WR = 1'b0,
      TOK_RD = 1'b1
   } tok_e;
endpackage

// File: rtl/cfifo_ptr.sv
module cfifo_ptr #(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          clr,
   output logic [AW-1:0] ptr,
   output logic          at_last
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   assign at_last = (ptr == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr <= '0;
      else if (clr)    ptr <= '0;
      else if (adv)    ptr <= at_last ? '0 : ptr + AW'(1);
   end
endmodule

// File: rtl/cfifo_token.sv
module cfifo_token
   import cfifo_pkg::*;
#(
   parameter bit   CHAINED = 1'b0,
   parameter tok_e KIND    = TOK_WR
) (
   input  logic clk,
   input  logic rst_n,
   input  logic first_ld_n,
   input  logic xin,
   input  logic xin_rd,
   input  logic give_up,
   output logic hold
);
   generate
      if (CHAINED) begin : g_ring
         logic take;
         assign take = xin && (xin_rd == logic'(KIND));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold <= ~first_ld_n;
            else        hold <= take | (hold & ~give_up);
         end
      end else begin : g_alone
         logic unused_tok;
         assign unused_tok = clk ^ rst_n ^ first_ld_n ^ xin ^ xin_rd ^ give_up;
         assign hold = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/cfifo_store.sv
module cfifo_store #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata,
   output logic             rvld
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         rvld  <= 1'b0;
      end else begin
         rvld <= re;
         if (re) rdata <= mem[raddr];
      end
   end
endmodule

// File: rtl/cfifo_count.sv
module cfifo_count #(
   parameter int DEPTH   = 8,
   parameter bit CHAINED = 1'b0,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          is_empty,
   output logic          is_full,
   output logic          empty_n,
   output logic          full_n,
   output logic          half_n
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (load)           cnt <= load_val;
      else if (inc && !dec)    cnt <= cnt + CW'(1);
      else if (dec && !inc)    cnt <= cnt - CW'(1);
   end

   assign is_empty = (cnt == '0);
   assign is_full  = (cnt == FULL_CNT);
   assign empty_n  = ~is_empty;
   assign full_n   = ~is_full;

   generate
      if (CHAINED) begin : g_half_off
         assign half_n = 1'b1;
      end else begin : g_half_on
         assign half_n = ~(cnt > HALF_CNT);
      end
   endgenerate
endmodule

// File: rtl/cfifo_slice.sv
module cfifo_slice
   import cfifo_pkg::*;
#(
   parameter int WIDTH   = 9,
   parameter int DEPTH   = 8,
   parameter bit CHAINED = 1'b0,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             dout_vld,
   input  logic             rt_n,
   input  logic             first_ld_n,
   input  logic             xin,
   input  logic             xin_rd,
   output logic             xout,
   output logic             xout_rd,
   output logic             empty_n,
   output logic             full_n,
   output logic             half_n
);
   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("cfifo_slice: DEPTH must be a power of two, at least 4");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("cfifo_slice: WIDTH must be at least 1");
      end
   endgenerate

   logic          w_hold, r_hold;
   logic          is_empty, is_full;
   logic          rew;
   logic          wr_fire, rd_fire;
   logic [AW-1:0] wptr, rptr;
   logic          w_last, r_last;
   logic          w_wrap, r_wrap;
   logic [CW-1:0] rew_cnt;

   generate
      if (CHAINED) begin : g_rew_off
         logic unused_rt;
         assign unused_rt = rt_n;
         assign rew = 1'b0;
      end else begin : g_rew_on
         assign rew = ~rt_n;
      end
   endgenerate

   assign wr_fire = ~wr_n & w_hold & ~is_full  & ~rew;
   assign rd_fire = ~rd_n & r_hold & ~is_empty & ~rew;
   assign w_wrap  = wr_fire & w_last;
   assign r_wrap  = rd_fire & r_last;
   assign rew_cnt = is_full ? CW'(DEPTH) : {1'b0, wptr};

   generate
      if (CHAINED) begin : g_xout_on
         assign xout    = w_wrap | r_wrap;
         assign xout_rd = r_wrap;
      end else begin : g_xout_off
         assign xout    = 1'b0;
         assign xout_rd = 1'b0;
      end
   endgenerate

   cfifo_ptr #(.DEPTH(DEPTH)) u_wptr (
      .clk(clk), .rst_n(rst_n), .adv(wr_fire), .clr(1'b0),
      .ptr(wptr), .at_last(w_last)
   );

   cfifo_ptr #(.DEPTH(DEPTH)) u_rptr (
      .clk(clk), .rst_n(rst_n), .adv(rd_fire), .clr(rew),
      .ptr(rptr), .at_last(r_last)
   );

   cfifo_token #(.CHAINED(CHAINED), .KIND(TOK_WR)) u_wtok (
      .clk(clk), .rst_n(rst_n), .first_ld_n(first_ld_n),
      .xin(xin), .xin_rd(xin_rd), .give_up(w_wrap), .hold(w_hold)
   );

   cfifo_token #(.CHAINED(CHAINED), .KIND(TOK_RD)) u_rtok (
      .clk(clk), .rst_n(rst_n), .first_ld_n(first_ld_n),
      .xin(xin), .xin_rd(xin_rd), .give_up(r_wrap), .hold(r_hold)
   );

   cfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(wr_fire), .waddr(wptr), .wdata(din),
      .re(rd_fire), .raddr(rptr), .rdata(dout), .rvld(dout_vld)
   );

   cfifo_count #(.DEPTH(DEPTH), .CHAINED(CHAINED)) u_count (
      .clk(clk), .rst_n(rst_n),
      .inc(wr_fire), .dec(rd_fire), .load(rew), .load_val(rew_cnt),
      .is_empty(is_empty), .is_full(is_full),
      .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
   );
endmodule

// File: rtl/cfifo_slice_chk.sv
module cfifo_slice_chk #(
   parameter bit CHAINED = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic rd_n,
   input logic rt_n,
   input logic xin,
   input logic xin_rd,
   input logic xout,
   input logic xout_rd,
   input logic empty_n,
   input logic full_n,
   input logic half_n,
   input logic dout_vld,
   input logic w_hold,
   input logic r_hold
);
   assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!empty_n && !full_n));

   assert_empty_no_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |=> !dout_vld);

   assert_full_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && rd_n && rt_n) |=> !full_n);

   assert_no_read_token_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !r_hold |=> !dout_vld);

   assert_tag_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      xout_rd |-> xout);

   assert_alone_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (CHAINED || !xout));

   assert_wr_give_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xout && !xout_rd && !(xin && !xin_rd)) |=> !w_hold);

   assert_rd_give_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xout && xout_rd && !(xin && xin_rd)) |=> !r_hold);

   assert_wr_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (CHAINED && xin && !xin_rd) |=> w_hold);

   assert_rd_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (CHAINED && xin && xin_rd) |=> r_hold);

   assert_half_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!CHAINED || half_n));
endmodule

bind cfifo_slice cfifo_slice_chk #(.CHAINED(CHAINED)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rt_n(rt_n),
   .xin(xin), .xin_rd(xin_rd), .xout(xout), .xout_rd(xout_rd),
   .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
   .dout_vld(dout_vld), .w_hold(w_hold), .r_hold(r_hold)
);

// File: tb/test_cfifo_slice.sv
`timescale 1ns/1ps
module test_cfifo_slice;
   localparam int W = 9;
   localparam int D = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // standalone slice
   logic         s_wr_n = 1'b1, s_rd_n = 1'b1, s_rt_n = 1'b1;
   logic [W-1:0] s_din = '0, s_dout;
   logic         s_vld, s_xo, s_xor, s_e, s_f, s_h;

   cfifo_slice #(.WIDTH(W), .DEPTH(D), .CHAINED(1'b0)) i_cfifo_slice (
      .clk(clk), .rst_n(rst_n), .wr_n(s_wr_n), .rd_n(s_rd_n), .din(s_din),
      .dout(s_dout), .dout_vld(s_vld), .rt_n(s_rt_n), .first_ld_n(1'b0),
      .xin(1'b0), .xin_rd(1'b0), .xout(s_xo), .xout_rd(s_xor),
      .empty_n(s_e), .full_n(s_f), .half_n(s_h)
   );

   // ring of three slices
   logic         c_wr_n = 1'b1, c_rd_n = 1'b1, c_rt_n = 1'b1;
   logic [W-1:0] c_din = '0;
   logic [W-1:0] c_dout [3];
   logic [2:0]   c_vld, c_x, c_xr, c_e, c_f, c_h;

   for (genvar k = 0; k < 3; k++) begin : g_ring
      cfifo_slice #(.WIDTH(W), .DEPTH(D), .CHAINED(1'b1)) i_cfifo_slice (
         .clk(clk), .rst_n(rst_n), .wr_n(c_wr_n), .rd_n(c_rd_n), .din(c_din),
         .dout(c_dout[k]), .dout_vld(c_vld[k]), .rt_n(c_rt_n),
         .first_ld_n(k != 0), .xin(c_x[(k+2)%3]), .xin_rd(c_xr[(k+2)%3]),
         .xout(c_x[k]), .xout_rd(c_xr[k]),
         .empty_n(c_e[k]), .full_n(c_f[k]), .half_n(c_h[k])
      );
   end

   logic [W-1:0] c_word;
   assign c_word = (c_vld[0] ? c_dout[0] : '0) | (c_vld[1] ? c_dout[1] : '0)
                 | (c_vld[2] ? c_dout[2] : '0);

   logic [2:0] pre_x, pre_xr;
   logic [W-1:0] q [$];

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      s_wr_n = 1'b1; s_rd_n = 1'b1; s_rt_n = 1'b1;
      c_wr_n = 1'b1; c_rd_n = 1'b1; c_rt_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      q.delete();
   endtask

   task automatic sstep(input bit w, input bit r, input logic [W-1:0] d, input bit rt);
      @(negedge clk);
      s_wr_n = ~w; s_rd_n = ~r; s_din = d; s_rt_n = ~rt;
      @(posedge clk);
      #1;
      s_wr_n = 1'b1; s_rd_n = 1'b1; s_rt_n = 1'b1;
   endtask

   task automatic cstep(input bit w, input bit r, input logic [W-1:0] d, input bit rt);
      @(negedge clk);
      c_wr_n = ~w; c_rd_n = ~r; c_din = d; c_rt_n = ~rt;
      #1;
      pre_x = c_x; pre_xr = c_xr;
      @(posedge clk);
      #1;
      c_wr_n = 1'b1; c_rd_n = 1'b1; c_rt_n = 1'b1;
   endtask

   function automatic logic [W-1:0] val(input int i);
      return W'(37 * i + 5);
   endfunction

   task automatic t_single_reset();
      do_reset();
      @(posedge clk); #1;
      chk("R2 reset empty_n", s_e, 0);
      chk("R3 reset full_n", s_f, 1);
      chk("R4 reset half_n", s_h, 1);
      chk("R1 reset dout_vld", s_vld, 0);
      chk("R9 alone xout", s_xo, 0);
   endtask

   task automatic t_single_fill();
      for (int i = 0; i < D; i++) begin
         sstep(1, 0, val(i), 0);
         q.push_back(val(i));
         chk("R4 half_n", s_h, (i + 1 > D / 2) ? 0 : 1);
         chk("R3 full_n", s_f, (i + 1 == D) ? 0 : 1);
      end
      chk("R9 alone xout after wrap", s_xo, 0);
      sstep(1, 0, 9'h1AA, 0);
      chk("R3 write when full", s_f, 0);
      for (int i = 0; i < D; i++) begin
         sstep(0, 1, '0, 0);
         chk("R1 read valid", s_vld, 1);
         chk("R1 read order", s_dout, q.pop_front());
      end
      chk("R2 empty after drain", s_e, 0);
      chk("R3 full write dropped", s_e, 0);
      sstep(0, 1, '0, 0);
      chk("R2 read of empty", s_vld, 0);
   endtask

   task automatic t_single_both();
      for (int i = 0; i < 3; i++) begin
         sstep(1, 0, val(100 + i), 0);
         q.push_back(val(100 + i));
      end
      for (int i = 0; i < 4; i++) begin
         sstep(1, 1, val(200 + i), 0);
         q.push_back(val(200 + i));
         chk("R5 both read", s_dout, q.pop_front());
         chk("R5 count kept empty_n", s_e, 1);
         chk("R5 count kept half_n", s_h, 1);
      end
      for (int i = 0; i < 3; i++) begin
         sstep(0, 1, '0, 0);
         chk("R5 remaining", s_dout, q.pop_front());
      end
      chk("R5 empty after three", s_e, 0);
   endtask

   task automatic t_single_rewind();
      do_reset();
      for (int i = 0; i < 5; i++) sstep(1, 0, val(300 + i), 0);
      for (int i = 0; i < 2; i++) begin
         sstep(0, 1, '0, 0);
         chk("R6 pre-rewind read", s_dout, val(300 + i));
      end
      sstep(1, 1, 9'h0F0, 1);
      chk("R6 no read at rewind", s_vld, 0);
      chk("R6 count five half_n", s_h, 0);
      for (int i = 0; i < 5; i++) begin
         sstep(0, 1, '0, 0);
         chk("R6 replay", s_dout, val(300 + i));
      end
      chk("R6 empty after replay", s_e, 0);
   endtask

   task automatic t_ring_reset();
      do_reset();
      @(posedge clk); #1;
      chk("R12 ring empty", |c_e, 0);
      chk("R12 ring not full", |c_f, 1);
      chk("R11 ring half_n", c_h, 3'b111);
   endtask

   task automatic t_ring_stream();
      for (int i = 0; i < 3 * D; i++) begin
         cstep(1, 0, val(400 + i), 0);
         q.push_back(val(400 + i));
         if (i == 0) begin
            chk("R7 first slice took write", c_e[0], 1);
            chk("R8 other slices ignore write", c_e[2:1], 2'b00);
            chk("R9 no pulse mid-slice", pre_x, 0);
         end
         if (i == D - 1)     chk("R9 write handoff 0", {pre_x, pre_xr}, 6'b001_000);
         if (i == 2 * D - 1) chk("R9 write handoff 1", {pre_x, pre_xr}, 6'b010_000);
         if (i == 3 * D - 1) chk("R10 ring write handoff 2", {pre_x, pre_xr}, 6'b100_000);
         if (i == D)         chk("R10 next slice loc 0", c_e[1], 1);
      end
      chk("R12 ring full", |c_f, 0);
      chk("R11 half_n chained full", c_h, 3'b111);
      cstep(1, 0, 9'h155, 0);
      cstep(0, 0, '0, 1);
      for (int i = 0; i < 3 * D; i++) begin
         cstep(0, 1, '0, 0);
         if (i == 0) chk("R8 only reader drives", c_vld, 3'b001);
         if (i == D - 1) chk("R9 read handoff 0", {pre_x, pre_xr}, 6'b001_001);
         chk("R12 ring order and R11 rewind ignored", c_word, q.pop_front());
      end
      chk("R12 ring empty after drain", |c_e, 0);
      cstep(0, 1, '0, 0);
      chk("R2 ring read of empty", c_vld, 0);
   endtask

   task automatic t_ring_lap();
      for (int i = 0; i < 12; i++) begin
         cstep(1, 0, val(500 + i), 0);
         q.push_back(val(500 + i));
      end
      for (int i = 0; i < 12; i++) begin
         cstep(1, 1, val(600 + i), 0);
         q.push_back(val(600 + i));
         chk("R5 ring both", c_word, q.pop_front());
      end
      for (int i = 0; i < 12; i++) begin
         cstep(0, 1, '0, 0);
         chk("R12 second lap order", c_word, q.pop_front());
      end
      chk("R12 empty after lap", |c_e, 0);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_single_reset();
      t_single_fill();
      t_single_both();
      t_single_rewind();
      t_ring_reset();
      t_ring_stream();
      t_ring_lap();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule